// File: doc/BRIEF.md
# Bit-Counting Logical Execution Unit

This block is the combinational core of a logical-operations lane in a 64-bit integer datapath. It takes two operands, an operation code and a few qualifier bits, and returns one 64-bit result in the same cycle. Three operations are plain bitwise combinations. The others count or fold bits: population count, low-bit parity and zero counting. Population count and parity run per partition, chosen by a length field. Zero counting runs over a 32-bit or 64-bit window, from either end.

An opaque context tag and a sticky-overflow flag travel beside the data. They are copied straight from input to output for every operation, including undefined ones, so that the pipeline stages on either side can track the instruction. The unit has no state. The operation decode is a single `unique case` over an enumerated opcode, with one arm for each operation: AND, OR, XOR, POP, PAR, ZCNT, and a default arm for NONE and RSV. Each counting variant is built by a generate loop that creates one instance for each partition size.

Top module: `lu_bitcount_unit`

## Requirements
- R1: Opcodes 1, 2 and 3 give the bitwise AND, OR and XOR of opa_i and opb_i, in that order.
- R2: Opcode 4 (population count) with len_i = 8 gives the number of set bits across all 64 bits of opa_i, zero-extended.
- R3: Opcode 4 with len_i = 4 gives two counts. Bits 31..0 hold the set-bit count of opa_i[31:0] and bits 63..32 hold the count of opa_i[63:32].
- R4: Opcode 4 with len_i = 1 gives, in each result byte k, the set-bit count of byte k of opa_i.
- R5: Opcode 5 (parity) with len_i = 8 places in bit 0 the XOR of opa_i bits 0, 8, 16 and so on up to 56. All other result bits are zero.
- R6: Opcode 5 with len_i = 4 places the XOR of bits 0, 8, 16 and 24 in result bit 0, and the XOR of bits 32, 40, 48 and 56 in result bit 32. All other result bits are zero.
- R7: Opcode 6 (zero count) with narrow_i = 0 scans all 64 bits. When trail_i = 1 it counts zeros upward from bit 0; when trail_i = 0 it counts downward from bit 63. An all-zero operand gives 64. The count is zero-extended from a 7-bit field.
- R8: Opcode 6 with narrow_i = 1 scans only opa_i[31:0]. Leading zeros are counted from bit 31, and an all-zero low half gives 32. opa_i[63:32] has no effect.
- R9: ctx_o equals ctx_i and sticky_o equals sticky_i for every opcode.
- R10: Opcodes 0 and 7 give a zero result. Opcodes 4 and 5 with a len_i value outside the values they define (1, 4, 8 for opcode 4; 4, 8 for opcode 5) also give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| len_i | input | 4 | Partition length in bytes for population count and parity |
| narrow_i | input | 1 | Selects the 32-bit window for zero counting |
| trail_i | input | 1 | 1 counts trailing zeros, 0 counts leading zeros |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| ctx_i | input | 8 | Opaque context tag |
| sticky_i | input | 1 | Sticky-overflow flag in |
| res_o | output | 64 | Result |
| ctx_o | output | 8 | Context tag out |
| sticky_o | output | 1 | Sticky-overflow flag out |

## Verification
The bench targets saturation of the zero counter on all-zero operands. A scan that stopped one bit short would return 63 or 31 instead of 64 or 32. It runs narrow-mode leading counts with junk in the upper half, which exposes a scan that starts at bit 63 instead of bit 31. It feeds all-ones operands to population count, where a count field one bit too narrow would wrap 8, 32 or 64 to zero. Parity patterns that set only the non-zero bits of each byte catch any folding of more than bit 0, and undefined opcodes and length codes catch a decode that lets a stale variant leak through.

// File: rtl/lu_pkg.sv
package lu_pkg;
    typedef enum logic [2:0] {
        LU_OP_NONE = 3'd0,
        LU_OP_AND  = 3'd1,
        LU_OP_OR   = 3'd2,
        LU_OP_XOR  = 3'd3,
        LU_OP_POP  = 3'd4,
        LU_OP_PAR  = 3'd5,
        LU_OP_ZCNT = 3'd6,
        LU_OP_RSV  = 3'd7
    } lu_op_e;

    localparam logic [3:0] LU_LEN_BYTE  = 4'd1;
    localparam logic [3:0] LU_LEN_WORD  = 4'd4;
    localparam logic [3:0] LU_LEN_DWORD = 4'd8;
endpackage

// File: rtl/lu_popcnt.sv
module lu_popcnt #(
    parameter int DATA_W = 64,
    parameter int GRAN   = 8
) (
    input  logic [DATA_W-1:0] a_i,
    output logic [DATA_W-1:0] cnt_o
);
    localparam int NCH = DATA_W / GRAN;
    localparam int CW  = $clog2(GRAN) + 1;

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        logic [CW-1:0] tally;

        always_comb begin
            tally = '0;
            for (int b = 0; b < GRAN; b++) begin
                tally = tally + CW'(a_i[c*GRAN + b]);
            end
        end

        assign cnt_o[c*GRAN +: GRAN] = GRAN'(tally);

        // Per-chunk tally agrees with a direct count (R2, R3, R4)
        always_comb begin
            if (!$isunknown(a_i)) begin
                assert_chunk_count_R4: assert (32'(tally) == 32'($countones(a_i[c*GRAN +: GRAN])))
                    else $error("chunk %0d count mismatch", c);
            end
        end
    end
endmodule

// File: rtl/lu_parity.sv
module lu_parity #(
    parameter int DATA_W = 64,
    parameter int SEG    = 64
) (
    input  logic [DATA_W-1:0] a_i,
    output logic [DATA_W-1:0] par_o
);
    localparam int NSEG = DATA_W / SEG;
    localparam int NB   = SEG / 8;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic fold;

        always_comb begin
            fold = 1'b0;
            for (int k = 0; k < NB; k++) begin
                fold = fold ^ a_i[s*SEG + k*8];
            end
        end

        assign par_o[s*SEG +: SEG] = SEG'(fold);
    end
endmodule

// File: rtl/lu_zcount.sv
module lu_zcount #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic              narrow_i,
    input  logic              trail_i,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int HALF = DATA_W / 2;

    int   lim;
    logic found;

    always_comb begin
        lim   = narrow_i ? HALF : DATA_W;
        cnt_o = '0;
        found = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < lim && !found) begin
                if (a_i[trail_i ? i : (lim - 1 - i)]) begin
                    found = 1'b1;
                end else begin
                    cnt_o = cnt_o + CNT_W'(1);
                end
            end
        end
    end

    // Saturated count if and only if the scanned window is empty (R7, R8)
    always_comb begin
        if (!$isunknown({a_i, narrow_i, trail_i})) begin
            assert_saturate_R7: assert ((cnt_o == CNT_W'(lim)) ==
                                        (narrow_i ? (a_i[HALF-1:0] == '0) : (a_i == '0)))
                else $error("zero count saturation mismatch");
            assert_window_R8: assert (!narrow_i || cnt_o <= CNT_W'(HALF))
                else $error("narrow count exceeds window");
        end
    end
endmodule

// File: rtl/lu_bitcount_unit.sv
module lu_bitcount_unit
    import lu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CTX_W  = 8
) (
    input  logic [2:0]        op_i,
    input  logic [3:0]        len_i,
    input  logic              narrow_i,
    input  logic              trail_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [CTX_W-1:0]  ctx_i,
    input  logic              sticky_i,
    output logic [DATA_W-1:0] res_o,
    output logic [CTX_W-1:0]  ctx_o,
    output logic              sticky_o
);
    localparam int HALF  = DATA_W / 2;
    localparam int CNT_W = $clog2(DATA_W) + 1;
    localparam int NPOP  = 3;
    localparam int NPAR  = 2;

    lu_op_e op;
    assign op = lu_op_e'(op_i);

    logic [DATA_W-1:0] pop_res [NPOP];
    logic [DATA_W-1:0] par_res [NPAR];
    logic [CNT_W-1:0]  zcnt;

    // index 0: byte, 1: word, 2: doubleword
    for (genvar g = 0; g < NPOP; g++) begin : g_pop
        localparam int GR = (g == 0) ? 8 : ((g == 1) ? HALF : DATA_W);
        lu_popcnt #(.DATA_W(DATA_W), .GRAN(GR)) u_pop (
            .a_i  (opa_i),
            .cnt_o(pop_res[g])
        );
    end

    // index 0: word, 1: doubleword
    for (genvar g = 0; g < NPAR; g++) begin : g_par
        localparam int SG = (g == 0) ? HALF : DATA_W;
        lu_parity #(.DATA_W(DATA_W), .SEG(SG)) u_par (
            .a_i  (opa_i),
            .par_o(par_res[g])
        );
    end

    lu_zcount #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_zcnt (
        .a_i     (opa_i),
        .narrow_i(narrow_i),
        .trail_i (trail_i),
        .cnt_o   (zcnt)
    );

    always_comb begin
        res_o = '0;
        unique case (op)
            LU_OP_AND:  res_o = opa_i & opb_i;
            LU_OP_OR:   res_o = opa_i | opb_i;
            LU_OP_XOR:  res_o = opa_i ^ opb_i;
            LU_OP_POP: begin
                case (len_i)
                    LU_LEN_BYTE:  res_o = pop_res[0];
                    LU_LEN_WORD:  res_o = pop_res[1];
                    LU_LEN_DWORD: res_o = pop_res[2];
                    default:      res_o = '0;
                endcase
            end
            LU_OP_PAR: begin
                case (len_i)
                    LU_LEN_WORD:  res_o = par_res[0];
                    LU_LEN_DWORD: res_o = par_res[1];
                    default:      res_o = '0;
                endcase
            end
            LU_OP_ZCNT: res_o = DATA_W'(zcnt);
            default:    res_o = '0;
        endcase
    end

    assign ctx_o    = ctx_i;
    assign sticky_o = sticky_i;

    always_comb begin
        if (!$isunknown({op_i, len_i, narrow_i, trail_i, opa_i, opb_i})) begin
            assert_undef_zero_R10: assert (!(op == LU_OP_NONE || op == LU_OP_RSV) || res_o == '0)
                else $error("undefined opcode gave a non-zero result");
            assert_parity_sparse_R6: assert (op != LU_OP_PAR ||
                    (res_o & ~((DATA_W'(1) << HALF) | DATA_W'(1))) == '0)
                else $error("parity result has stray bits");
            assert_zcnt_width_R7: assert (op != LU_OP_ZCNT || (res_o >> CNT_W) == '0)
                else $error("zero count spills above its field");
            assert_and_subset_R1: assert (op != LU_OP_AND || (res_o & ~opa_i) == '0)
                else $error("AND result sets a bit absent from operand A");
        end
    end
endmodule

// File: tb/lu_bitcount_unit_tb.sv
module lu_bitcount_unit_tb;
    logic        clk = 1'b0;
    logic [2:0]  op_i = '0;
    logic [3:0]  len_i = '0;
    logic        narrow_i = 1'b0;
    logic        trail_i = 1'b0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [7:0]  ctx_i = '0;
    logic        sticky_i = 1'b0;
    logic [63:0] res_o;
    logic [7:0]  ctx_o;
    logic        sticky_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [63:0] exp_q [$];
    logic [8:0]  side_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    lu_bitcount_unit u_dut (
        .op_i(op_i), .len_i(len_i), .narrow_i(narrow_i), .trail_i(trail_i),
        .opa_i(opa_i), .opb_i(opb_i), .ctx_i(ctx_i), .sticky_i(sticky_i),
        .res_o(res_o), .ctx_o(ctx_o), .sticky_o(sticky_o)
    );

    function automatic logic [63:0] model(input logic [2:0] op, input logic [3:0] len,
                                          input logic nar, input logic tr,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        int n, w;
        r = '0;
        case (op)
            3'd1: r = a & b;
            3'd2: r = a | b;
            3'd3: r = a ^ b;
            3'd4: begin
                if (len == 4'd8) r = 64'($countones(a));
                else if (len == 4'd4) r = {32'($countones(a[63:32])), 32'($countones(a[31:0]))};
                else if (len == 4'd1)
                    for (int k = 0; k < 8; k++) r[k*8 +: 8] = 8'($countones(a[k*8 +: 8]));
            end
            3'd5: begin
                if (len == 4'd8) begin
                    for (int k = 0; k < 8; k++) r[0] = r[0] ^ a[8*k];
                end else if (len == 4'd4) begin
                    for (int k = 0; k < 4; k++) begin
                        r[0]  = r[0]  ^ a[8*k];
                        r[32] = r[32] ^ a[32 + 8*k];
                    end
                end
            end
            3'd6: begin
                w = nar ? 32 : 64;
                n = 0;
                if (tr) while (n < w && !a[n]) n++;
                else    while (n < w && !a[w-1-n]) n++;
                r = 64'(n);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // Driver: apply one stimulus and push what the monitor must see
    task automatic drive(input string tag, input logic [2:0] op, input logic [3:0] len,
                         input logic nar, input logic tr,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [7:0] ctx, input logic so);
        @(posedge clk);
        #0.5;
        op_i = op; len_i = len; narrow_i = nar; trail_i = tr;
        opa_i = a; opb_i = b; ctx_i = ctx; sticky_i = so;
        exp_q.push_back(model(op, len, nar, tr, a, b));
        side_q.push_back({so, ctx});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare at the falling edge, mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [63:0] e;
            logic [8:0]  s;
            string       t;
            e = exp_q.pop_front();
            s = side_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (res_o !== e) begin
                bad++;
                $display("FAIL %s res actual=%h expected=%h", t, res_o, e);
            end
            total++;
            if ({sticky_o, ctx_o} !== s) begin
                bad++;
                $display("FAIL R9 (%s) side actual=%h expected=%h", t, {sticky_o, ctx_o}, s);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] lf;
        lf = 64'h9E37_79B9_7F4A_7C15;
        // idle state: undefined opcode 0 on zero inputs (R10)
        drive("R10", 3'd0, 4'd0, 0, 0, 64'h0, 64'h0, 8'h00, 0);
        // R1 bitwise
        drive("R1", 3'd1, 4'd0, 0, 0, 64'hDEADBEEFCAFEC0DE, 64'hD0ADB0000AFEC1DE, 8'h11, 1);
        drive("R1", 3'd2, 4'd0, 0, 0, 64'hDEADBEEFCAFEC0DE, 64'hD0ADB0000AFEC1DE, 8'h12, 0);
        drive("R1", 3'd3, 4'd0, 0, 0, 64'hDEADBEEFCAFEC0DE, 64'hD0ADB0000AFEC1DE, 8'h13, 1);
        // R2 R3 R4 all-ones saturate the widest count of each partition
        drive("R2", 3'd4, 4'd8, 0, 0, '1, 64'h0, 8'h21, 0);
        drive("R3", 3'd4, 4'd4, 0, 0, '1, 64'h0, 8'h22, 1);
        drive("R4", 3'd4, 4'd1, 0, 0, '1, 64'h0, 8'h23, 0);
        drive("R4", 3'd4, 4'd1, 0, 0, 64'h0103_070F_1F3F_7F00, 64'h0, 8'h24, 1);
        drive("R3", 3'd4, 4'd4, 0, 0, 64'h0000_0001_FFFF_0000, 64'h0, 8'h25, 0);
        // R5 R6 parity: upper bits of bytes must be ignored
        drive("R5", 3'd5, 4'd8, 0, 0, 64'hFEFE_FEFE_FEFE_FEFE, 64'h0, 8'h31, 0);
        drive("R5", 3'd5, 4'd8, 0, 0, 64'h0000_0000_0000_0101, 64'h0, 8'h32, 1);
        drive("R5", 3'd5, 4'd8, 0, 0, 64'h0001_0000_0000_0100, 64'h0, 8'h33, 0);
        drive("R6", 3'd5, 4'd4, 0, 0, 64'h0000_0001_0000_0001, 64'h0, 8'h34, 1);
        drive("R6", 3'd5, 4'd4, 0, 0, 64'h0101_0100_0000_0001, 64'h0, 8'h35, 0);
        // R7 64-bit zero counts
        drive("R7", 3'd6, 4'd0, 0, 0, 64'h0, 64'h0, 8'h41, 0);
        drive("R7", 3'd6, 4'd0, 0, 1, 64'h0, 64'h0, 8'h42, 1);
        drive("R7", 3'd6, 4'd0, 0, 0, 64'h1, 64'h0, 8'h43, 0);
        drive("R7", 3'd6, 4'd0, 0, 1, 64'h1, 64'h0, 8'h44, 0);
        drive("R7", 3'd6, 4'd0, 0, 0, 64'h8000_0000_0000_0000, 64'h0, 8'h45, 1);
        drive("R7", 3'd6, 4'd0, 0, 1, 64'h8000_0000_0000_0000, 64'h0, 8'h46, 0);
        // R8 narrow window ignores the upper half
        drive("R8", 3'd6, 4'd0, 1, 0, 64'hFFFF_FFFF_0000_0000, 64'h0, 8'h51, 0);
        drive("R8", 3'd6, 4'd0, 1, 1, 64'hFFFF_FFFF_0000_0000, 64'h0, 8'h52, 1);
        drive("R8", 3'd6, 4'd0, 1, 0, 64'hA5A5_A5A5_0000_0001, 64'h0, 8'h53, 0);
        drive("R8", 3'd6, 4'd0, 1, 1, 64'h1234_5678_8000_0000, 64'h0, 8'h54, 1);
        // R10 undefined codes and lengths
        drive("R10", 3'd7, 4'd8, 0, 0, '1, '1, 8'h61, 1);
        drive("R10", 3'd4, 4'd2, 0, 0, '1, '1, 8'h62, 0);
        drive("R10", 3'd5, 4'd1, 0, 0, '1, '1, 8'h63, 1);
        // mixed sweep across every opcode (R9 on each)
        for (int i = 0; i < 64; i++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            drive("R9", 3'(i % 8), (i % 3 == 0) ? 4'd1 : ((i % 3 == 1) ? 4'd4 : 4'd8),
                  1'(i / 8), 1'(i / 16), lf, ~{lf[31:0], lf[63:32]}, 8'(i * 7), 1'(i));
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule